// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block holds a small set of recently used translations from a virtual page number to a physical frame number. In a single cycle, a lookup compares the requested page against every stored tag at once. It then returns the frame number, the cached permission and dirty state, and a hit flag. The lookup path has no register, so the result belongs to the cycle in which the page is presented.

When a lookup misses, the page-table walker resolves the page and installs the result through the fill port. No software step is involved. Two maintenance inputs keep the contents coherent:

- An address-space switch drops every entry that is not marked global.
- A single-page invalidate drops the one entry whose tag matches.

A write to a page that is cached as clean, or as not writable, reports a miss. The walker then gets the chance to update the table entry, or to raise a fault.

Top module: `xlat_cache`

## Requirements
- R1: While reset is held and after it is released, every entry is empty and every lookup returns lk_hit = 0, including lookups of page 0.
- R2: After a fill is accepted, a lookup of the filled page in any later cycle returns lk_hit = 1. In the same cycle as that lookup, lk_pfn, lk_user, lk_writable and lk_dirty carry the values given at the fill.
- R3: A read lookup (lk_write = 0) hits on any stored page. A write lookup (lk_write = 1) hits only if the stored entry has both lk_dirty = 1 and lk_writable = 1; otherwise it reports lk_hit = 0.
- R4: Filling a page that is already stored overwrites that entry in place. Only one entry ever matches a page, and the lookup returns only the newest frame number.
- R5: A fill of a page that is not stored goes to the lowest-numbered empty slot. If no slot is empty, it goes to the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, only on a fill that displaces a stored entry.
- R6: An address-space flush (flush_en = 1) empties every entry whose global flag is 0. Entries filled with fill_global = 1 keep hitting.
- R7: A single-page invalidate (inv_en = 1) empties the entry whose tag equals inv_vpn, whether or not it is global. All other entries are unaffected.
- R8: A fill in the same cycle as flush_en or inv_en is discarded. The flush or invalidate still takes effect.
- R9: An invalidate of a page that is not stored changes nothing. Every stored page still hits afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_write | input | 1 | Lookup is for a write access |
| lk_hit | output | 1 | Translation usable for this access |
| lk_pfn | output | PFN_W | Frame number of the matching entry (0 if no tag match) |
| lk_user | output | 1 | Matching entry allows user-level access |
| lk_writable | output | 1 | Matching entry allows writes |
| lk_dirty | output | 1 | Matching entry is cached as already written |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_user | input | 1 | User-access flag to install |
| fill_writable | input | 1 | Write-permission flag to install |
| fill_dirty | input | 1 | Dirty flag to install |
| fill_global | input | 1 | Entry survives address-space flushes |
| flush_en | input | 1 | Address-space switch: drop non-global entries |
| inv_en | input | 1 | Drop the entry matching inv_vpn |
| inv_vpn | input | VPN_W | Page number to invalidate |

## Verification
The two functions that can fall in the same cycle are a fill from the walker and a maintenance action, either a flush or a single-page invalidate. The bench provokes this by driving fill_en together with flush_en, and in a separate case together with inv_en, on the same clock edge. The judgement comes from lookups in the following cycles:

- The page offered for fill must miss.
- A global page that was already stored must still hit after the flush.
- The page named by the invalidate must miss.

A second overlap also gets attention: a refill of a page that is already stored, while the pointer or the free-slot search would pick a different slot. Here the frame numbers are chosen so that a duplicate entry would return a visibly wrong value.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   // Per-entry permission and state flags kept beside each tag.
   typedef struct packed {
      logic user;
      logic writable;
      logic dirty;
      logic global_map;
   } xlat_flags_t;

endpackage

// File: rtl/xlat_cam_match.sv
module xlat_cam_match #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20
) (
   input  logic [ENTRIES-1:0]            valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
   input  logic [VPN_W-1:0]              key,
   output logic [ENTRIES-1:0]            hit
);

   // One comparator per slot, all evaluated in parallel.
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit[g] = valid[g] && (tags[g] == key);
   end

endmodule

// File: rtl/xlat_first_one.sv
module xlat_first_one #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   // Lowest set bit wins.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid,
   input  logic               advance,
   output logic               free_found,
   output logic [IDX_W-1:0]   victim
);

   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] ptr_q;

   xlat_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) i_free (
      .vec   (~valid),
      .found (free_found),
      .idx   (free_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (advance) begin
         ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

   assign victim = free_found ? free_idx : ptr_q;

   // Pointer never leaves the slot range.
   assert_ptr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= IDX_W'(ENTRIES - 1));

   // Pointer moves only when a stored entry is displaced.
   assert_ptr_moves_on_evict_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr_q));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic             lk_write,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   output logic             lk_user,
   output logic             lk_writable,
   output logic             lk_dirty,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic             fill_user,
   input  logic             fill_writable,
   input  logic             fill_dirty,
   input  logic             fill_global,
   input  logic             flush_en,
   input  logic             inv_en,
   input  logic [VPN_W-1:0] inv_vpn
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PFN_W < 1) begin : g_bad_width
      $error("xlat_cache: page and frame widths must be positive");
   end

   logic [ENTRIES-1:0]            valid_q;
   logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
   logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
   xlat_flags_t                   flags_q [ENTRIES];
   logic [ENTRIES-1:0]            glob_q;

   logic [ENTRIES-1:0] lk_match, fill_match, inv_match;
   logic               lk_found, fill_present, free_found;
   logic [IDX_W-1:0]   lk_idx, fill_idx, victim_idx, slot;
   logic               fill_commit, advance;

   // ---------------- tag compare ----------------
   xlat_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_cmp_lk (
      .valid (valid_q), .tags (tag_q), .key (lk_vpn), .hit (lk_match)
   );
   xlat_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_cmp_fill (
      .valid (valid_q), .tags (tag_q), .key (fill_vpn), .hit (fill_match)
   );
   xlat_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_cmp_inv (
      .valid (valid_q), .tags (tag_q), .key (inv_vpn), .hit (inv_match)
   );

   xlat_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) i_enc_lk (
      .vec (lk_match), .found (lk_found), .idx (lk_idx)
   );
   xlat_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) i_enc_fill (
      .vec (fill_match), .found (fill_present), .idx (fill_idx)
   );

   // ---------------- fill arbitration and slot choice ----------------
   assign fill_commit = fill_en && !flush_en && !inv_en;
   assign advance     = fill_commit && !fill_present && !free_found;
   assign slot        = fill_present ? fill_idx : victim_idx;

   xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (valid_q),
      .advance    (advance),
      .free_found (free_found),
      .victim     (victim_idx)
   );

   // ---------------- entry storage ----------------
   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      logic wr_this, kill;
      assign wr_this   = fill_commit && (slot == IDX_W'(g));
      assign kill      = (flush_en && !flags_q[g].global_map) || (inv_en && inv_match[g]);
      assign glob_q[g] = flags_q[g].global_map;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
         end else if (kill) begin
            valid_q[g] <= 1'b0;
         end else if (wr_this) begin
            valid_q[g] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q[g]   <= '0;
            pfn_q[g]   <= '0;
            flags_q[g] <= '0;
         end else if (wr_this) begin
            tag_q[g]   <= fill_vpn;
            pfn_q[g]   <= fill_pfn;
            flags_q[g] <= '{user: fill_user, writable: fill_writable,
                            dirty: fill_dirty, global_map: fill_global};
         end
      end
   end

   // ---------------- lookup result ----------------
   always_comb begin
      lk_pfn      = '0;
      lk_user     = 1'b0;
      lk_writable = 1'b0;
      lk_dirty    = 1'b0;
      if (lk_found) begin
         lk_pfn      = pfn_q[lk_idx];
         lk_user     = flags_q[lk_idx].user;
         lk_writable = flags_q[lk_idx].writable;
         lk_dirty    = flags_q[lk_idx].dirty;
      end
   end

   // A write through a clean or read-only entry goes back to the walker.
   assign lk_hit = lk_found && !(lk_write && !(lk_dirty && lk_writable));

   // ---------------- assertions ----------------
   assert_reset_empty_R1: assert property (@(posedge clk)
      !rst_n |=> (valid_q == '0));

   assert_fill_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fill_commit |=> valid_q[$past(slot)]);

   assert_write_needs_rights_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && lk_write) |-> (lk_dirty && lk_writable));

   assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   assert_flush_keeps_global_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_en && !inv_en) |=> (valid_q == ($past(valid_q) & $past(glob_q))));

   assert_inv_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en |=> ((valid_q & $past(inv_match)) == '0));

   assert_maint_beats_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_en || inv_en) |=> ($countones(valid_q) <= $past($countones(valid_q))));

endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;

   localparam int VW = 20;
   localparam int PW = 20;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [VW-1:0] lk_vpn;
   logic          lk_write;
   logic          lk_hit;
   logic [PW-1:0] lk_pfn;
   logic          lk_user, lk_writable, lk_dirty;
   logic          fill_en;
   logic [VW-1:0] fill_vpn;
   logic [PW-1:0] fill_pfn;
   logic          fill_user, fill_writable, fill_dirty, fill_global;
   logic          flush_en, inv_en;
   logic [VW-1:0] inv_vpn;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   xlat_cache i_xlat_cache (
      .clk (clk), .rst_n (rst_n),
      .lk_vpn (lk_vpn), .lk_write (lk_write), .lk_hit (lk_hit), .lk_pfn (lk_pfn),
      .lk_user (lk_user), .lk_writable (lk_writable), .lk_dirty (lk_dirty),
      .fill_en (fill_en), .fill_vpn (fill_vpn), .fill_pfn (fill_pfn),
      .fill_user (fill_user), .fill_writable (fill_writable),
      .fill_dirty (fill_dirty), .fill_global (fill_global),
      .flush_en (flush_en), .inv_en (inv_en), .inv_vpn (inv_vpn)
   );

   typedef struct {
      logic [VW-1:0] vpn;
      logic          hit;
      logic [PW-1:0] pfn;
      logic          usr, wrt, drt;
      string         req;
   } exp_t;

   exp_t sb[$];

   task automatic idle_inputs();
      lk_vpn = '0; lk_write = 1'b0;
      fill_en = 1'b0; fill_vpn = '0; fill_pfn = '0;
      fill_user = 1'b0; fill_writable = 1'b0; fill_dirty = 1'b0; fill_global = 1'b0;
      flush_en = 1'b0; inv_en = 1'b0; inv_vpn = '0;
   endtask

   // Driver: present a lookup and push the expected result.
   task automatic look(input logic [VW-1:0] vpn, input logic wr, input logic hit,
                       input logic [PW-1:0] pfn, input logic usr, input logic wrt,
                       input logic drt, input string req);
      exp_t e;
      @(negedge clk);
      idle_inputs();
      lk_vpn = vpn; lk_write = wr;
      e.vpn = vpn; e.hit = hit; e.pfn = pfn; e.usr = usr; e.wrt = wrt; e.drt = drt;
      e.req = req;
      sb.push_back(e);
   endtask

   task automatic fill(input logic [VW-1:0] vpn, input logic [PW-1:0] pfn,
                       input logic usr, input logic wrt, input logic drt,
                       input logic glb, input logic fl, input logic iv,
                       input logic [VW-1:0] ivpn);
      @(negedge clk);
      idle_inputs();
      fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
      fill_user = usr; fill_writable = wrt; fill_dirty = drt; fill_global = glb;
      flush_en = fl; inv_en = iv; inv_vpn = ivpn;
   endtask

   task automatic maint(input logic fl, input logic iv, input logic [VW-1:0] ivpn);
      @(negedge clk);
      idle_inputs();
      flush_en = fl; inv_en = iv; inv_vpn = ivpn;
   endtask

   task automatic hit_rd(input logic [VW-1:0] vpn, input logic [PW-1:0] pfn, input string req);
      look(vpn, 1'b0, 1'b1, pfn, 1'b0, 1'b1, 1'b0, req);
   endtask

   task automatic miss(input logic [VW-1:0] vpn, input logic wr, input string req);
      look(vpn, wr, 1'b0, '0, 1'b0, 1'b0, 1'b0, req);
   endtask

   // Monitor: compare the combinational lookup result 2 ns after the drive edge.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (lk_hit !== e.hit) begin
               errors++;
               $display("FAIL %s vpn %h: hit %0b expected %0b", e.req, e.vpn, lk_hit, e.hit);
            end else if (e.hit && {lk_pfn, lk_user, lk_writable, lk_dirty} !==
                                  {e.pfn, e.usr, e.wrt, e.drt}) begin
               errors++;
               $display("FAIL %s vpn %h: pfn/u/w/d %h/%0b/%0b/%0b expected %h/%0b/%0b/%0b",
                        e.req, e.vpn, lk_pfn, lk_user, lk_writable, lk_dirty,
                        e.pfn, e.usr, e.wrt, e.drt);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset, page 0 included
      miss(20'h00000, 1'b0, "R1");
      miss(20'h00001, 1'b0, "R1");

      // R2 / R3: fill and read back, write rights
      fill(20'h12345, 20'h0AAAA, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      look(20'h12345, 1'b0, 1'b1, 20'h0AAAA, 1'b1, 1'b1, 1'b1, "R2");
      look(20'h12345, 1'b1, 1'b1, 20'h0AAAA, 1'b1, 1'b1, 1'b1, "R3");
      fill(20'h00042, 20'h0BBBB, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      look(20'h00042, 1'b0, 1'b1, 20'h0BBBB, 1'b0, 1'b1, 1'b0, "R2");
      miss(20'h00042, 1'b1, "R3");
      fill(20'h00077, 20'h0CCCC, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      look(20'h00077, 1'b0, 1'b1, 20'h0CCCC, 1'b0, 1'b0, 1'b1, "R3");
      miss(20'h00077, 1'b1, "R3");

      // R4: refill of a stored page overwrites in place
      fill(20'h12345, 20'h05555, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      look(20'h12345, 1'b0, 1'b1, 20'h05555, 1'b1, 1'b1, 1'b1, "R4");

      // R9: invalidate of an absent page
      maint(1'b0, 1'b1, 20'h99999);
      look(20'h12345, 1'b0, 1'b1, 20'h05555, 1'b1, 1'b1, 1'b1, "R9");
      look(20'h00042, 1'b0, 1'b1, 20'h0BBBB, 1'b0, 1'b1, 1'b0, "R9");
      look(20'h00077, 1'b0, 1'b1, 20'h0CCCC, 1'b0, 1'b0, 1'b1, "R9");

      // R7: single-page invalidate, global entry included
      fill(20'h00300, 20'h03300, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      hit_rd(20'h00300, 20'h03300, "R7");
      maint(1'b0, 1'b1, 20'h00042);
      miss(20'h00042, 1'b0, "R7");
      look(20'h12345, 1'b0, 1'b1, 20'h05555, 1'b1, 1'b1, 1'b1, "R7");
      maint(1'b0, 1'b1, 20'h00300);
      miss(20'h00300, 1'b0, "R7");

      // R6: address-space flush keeps global entries
      fill(20'h00300, 20'h03300, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      maint(1'b1, 1'b0, '0);
      miss(20'h12345, 1'b0, "R6");
      miss(20'h00077, 1'b0, "R6");
      hit_rd(20'h00300, 20'h03300, "R6");

      // R8: flush or invalidate in the same cycle as a fill wins
      fill(20'h00400, 20'h04400, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0);
      miss(20'h00400, 1'b0, "R8");
      hit_rd(20'h00300, 20'h03300, "R8");
      fill(20'h00500, 20'h04500, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 20'h00300);
      miss(20'h00500, 1'b0, "R8");
      miss(20'h00300, 1'b0, "R8");

      // R5: free slots first, then round robin from slot 0
      for (int i = 0; i < 8; i++) begin
         fill(20'h01000 + VW'(i), 20'h02000 + PW'(i), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      end
      hit_rd(20'h01000, 20'h02000, "R5");
      hit_rd(20'h01007, 20'h02007, "R5");
      fill(20'h01008, 20'h02008, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      miss(20'h01000, 1'b0, "R5");
      hit_rd(20'h01008, 20'h02008, "R5");
      hit_rd(20'h01001, 20'h02001, "R5");
      fill(20'h01009, 20'h02009, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      miss(20'h01001, 1'b0, "R5");
      maint(1'b0, 1'b1, 20'h01003);
      fill(20'h0100A, 20'h0200A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      hit_rd(20'h01002, 20'h02002, "R5");
      miss(20'h01003, 1'b0, "R5");
      hit_rd(20'h0100A, 20'h0200A, "R5");

      @(negedge clk);
      idle_inputs();
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule